// File: doc/BRIEF.md
# Multichannel Successive-Approximation Conversion Sequencer

This block is the digital controller of a 16-channel recording front end. The channels sit in two groups of eight. Each group has its own 8-to-1 analog selector feeding its own 10-bit successive-approximation converter. The controller runs from the converter clock (2.5 MHz, 0.4 µs per cycle). It steps through the channels in a fixed repeating order and gives each one a slot of 24 clocks. Each slot holds 13 clocks of sampling, then 10 clocks of bit decisions, then one end-of-conversion clock.

For each group the block holds the approximation register. It presents the trial code to that group's capacitor DAC and takes one comparator decision per conversion clock. When a slot ends, the finished word of the group that just converted passes through a digital output multiplexer into a shift register. During the next slot the word leaves on a single serial pin, most significant bit first, with a frame marker on the first bit.

Top module: `mc_sar_sequencer`

## Requirements
- R1: A slot is 24 clocks, counted 0 to 23. Clocks 0-12 sample, clocks 13-22 make one bit decision each, and `eoc_o` is high during clock 23 only, for exactly one cycle.
- R2: The active group's `dac_code_o` field shows the bits already decided plus the trial bit, most significant bit first. In clock 13 it is 512 (trial bit 9 only). A comparator value of 1 keeps the trial bit and 0 clears it. In clock 23 the field equals the largest code not above the comparator's threshold.
- R3: In sample clocks (0-12) the active group's code is 0. The comparator input is ignored in clocks 0-12 and 23, so the final result does not depend on it there.
- R4: The group that is not converting holds a code of 0 and ignores its comparator input.
- R5: `ch_sel_o` steps 0,1,...,15,0,... and advances once per slot, after clock 23. Bit 3 selects the group (0 = first group) and bits 2:0 select the selector input.
- R6: `ch_sel_o` stays constant from clock 0 to clock 23 of a slot.
- R7: The word finished in one slot appears on `dout_o` in clocks 0-9 of the next slot, bit 9 first. `frame_o` is high in clock 0 of that slot only. `dout_o` is 0 in clocks 10-23.
- R8: `dsel_o` is one-hot for the group whose word is being shifted out: bit 0 for channels 0-7 and bit 1 for channels 8-15. It changes only at a slot boundary.
- R9: Reset, even in the middle of a conversion, returns the block to channel 0, clock 0, with all codes 0 and `eoc_o`, `frame_o`, `dout_o` and `dsel_o` all 0. No frame is sent in the first slot after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 2 | Comparator decision per group (bit g for group g), 1 = keep the trial bit |
| dac_code_o | output | 20 | Trial code per group; bits 9:0 are group 0 and bits 19:10 are group 1 |
| ch_sel_o | output | 4 | Analog channel select: bit 3 is the group, bits 2:0 the selector input |
| eoc_o | output | 1 | End-of-conversion strobe, high in the last clock of a slot |
| dsel_o | output | 2 | One-hot select of the digital output multiplexer |
| dout_o | output | 1 | Serial data, most significant bit first |
| frame_o | output | 1 | Marks the first serial bit of a word |

## Verification
At clock 23 of a slot, several things happen on one edge. The finished word is captured into the serializer, the digital select moves to the group that just finished, and the analog select moves on. At the 7-to-8 and 15-to-0 boundaries it moves to the other group, whose register starts a fresh sample phase. These boundaries come up on every pass of the rotation, and the bench runs three passes with different threshold sets. The bench checks that the serial bits in the next slot carry the old channel's threshold, with the matching `dsel_o` bit, while `ch_sel_o` already names the new channel. A reset in the middle of a conversion is also placed on a slot that holds a pending serial word, to confirm that no frame leaks out afterwards.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_CONV   = 2'd1,
    PH_EOC    = 2'd2
  } phase_e;
endpackage

// File: rtl/sarseq_slot_timer.sv
module sarseq_slot_timer
  import sarseq_pkg::*;
#(
  parameter int SAMPLE_CYC = 13,
  parameter int RES        = 10,
  parameter int NCH        = 16,
  localparam int SLOT      = SAMPLE_CYC + RES + 1,
  localparam int CW        = $clog2(SLOT),
  localparam int HW        = $clog2(NCH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cyc_o,
  output logic [HW-1:0] ch_o,
  output phase_e        phase_o,
  output logic          last_o
);
  logic [CW-1:0] cyc_q;
  logic [HW-1:0] ch_q;

  assign last_o = (cyc_q == CW'(SLOT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      ch_q  <= '0;
    end else if (last_o) begin
      cyc_q <= '0;
      ch_q  <= (ch_q == HW'(NCH - 1)) ? '0 : ch_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  always_comb begin
    if (cyc_q < CW'(SAMPLE_CYC))            phase_o = PH_SAMPLE;
    else if (cyc_q < CW'(SAMPLE_CYC + RES)) phase_o = PH_CONV;
    else                                    phase_o = PH_EOC;
  end

  assign cyc_o = cyc_q;
  assign ch_o  = ch_q;

  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (cyc_q == '0)); // R1
  AST_CH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> $stable(ch_q)); // R6
  AST_CH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (ch_q == HW'((int'($past(ch_q)) + 1) % NCH))); // R5
endmodule

// File: rtl/sarseq_sar_core.sv
module sarseq_sar_core
  import sarseq_pkg::*;
#(
  parameter int RES        = 10,
  parameter int SAMPLE_CYC = 13,
  parameter int CW         = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           active_i,
  input  phase_e         phase_i,
  input  logic [CW-1:0]  cyc_i,
  input  logic           cmp_i,
  output logic [RES-1:0] code_o
);
  localparam logic [RES-1:0] MSB = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] code_q;
  logic [RES-1:0] mask_q;   // one-hot trial bit, shifts right per decision

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (active_i) begin
      unique case (phase_i)
        PH_SAMPLE: begin
          if (cyc_i == CW'(SAMPLE_CYC - 1)) begin
            code_q <= MSB;
            mask_q <= MSB;
          end
        end
        PH_CONV: begin
          code_q <= (code_q & ~mask_q) | (cmp_i ? mask_q : '0) | (mask_q >> 1);
          mask_q <= mask_q >> 1;
        end
        default: begin
          code_q <= '0;
          mask_q <= '0;
        end
      endcase
    end
  end

  assign code_o = code_q;

  AST_SAMPLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && phase_i == PH_SAMPLE) |-> (code_o == '0)); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (code_o == '0)); // R4
  AST_EOC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && phase_i == PH_EOC) |=> (code_o == '0)); // R3
endmodule

// File: rtl/sarseq_serializer.sv
module sarseq_serializer #(
  parameter int RES  = 10,
  parameter int NSUB = 2,
  parameter int CW   = 5,
  localparam int SW  = (NSUB > 1) ? $clog2(NSUB) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                last_i,
  input  logic [CW-1:0]       cyc_i,
  input  logic [SW-1:0]       sub_i,
  input  logic [NSUB*RES-1:0] word_i,
  output logic                dout_o,
  output logic                frame_o,
  output logic [NSUB-1:0]     dsel_o
);
  logic [RES-1:0]  sel_word;
  logic [RES-1:0]  sh_q;
  logic [NSUB-1:0] dsel_q;
  logic            valid_q;

  always_comb begin
    sel_word = '0;
    for (int s = 0; s < NSUB; s++)
      if (sub_i == SW'(s)) sel_word = word_i[s*RES +: RES];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      dsel_q  <= '0;
      valid_q <= 1'b0;
    end else if (last_i) begin
      sh_q    <= sel_word;
      dsel_q  <= NSUB'(1) << sub_i;
      valid_q <= 1'b1;
    end else if (cyc_i < CW'(RES)) begin
      sh_q <= sh_q << 1;
    end
  end

  assign dout_o  = valid_q && (cyc_i < CW'(RES)) && sh_q[RES-1];
  assign frame_o = valid_q && (cyc_i == '0);
  assign dsel_o  = dsel_q;

  AST_FRAME_AFTER_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> $past(last_i)); // R7
  AST_DSEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dsel_o)); // R8
  AST_DSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(dsel_o)); // R8
endmodule

// File: rtl/mc_sar_sequencer.sv
module mc_sar_sequencer
  import sarseq_pkg::*;
#(
  parameter int RES        = 10,
  parameter int SAMPLE_CYC = 13,
  parameter int CH_PER_SUB = 8,
  parameter int NSUB       = 2,
  localparam int NCH       = CH_PER_SUB * NSUB,
  localparam int HW        = $clog2(NCH),
  localparam int MW        = $clog2(CH_PER_SUB),
  localparam int SW        = (NSUB > 1) ? $clog2(NSUB) : 1,
  localparam int SLOT      = SAMPLE_CYC + RES + 1,
  localparam int CW        = $clog2(SLOT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NSUB-1:0]     cmp_i,
  output logic [NSUB*RES-1:0] dac_code_o,
  output logic [HW-1:0]       ch_sel_o,
  output logic                eoc_o,
  output logic [NSUB-1:0]     dsel_o,
  output logic                dout_o,
  output logic                frame_o
);
  logic [CW-1:0] cyc;
  logic [HW-1:0] ch;
  phase_e        phase;
  logic          last;
  logic [SW-1:0] sub;

  sarseq_slot_timer #(
    .SAMPLE_CYC(SAMPLE_CYC), .RES(RES), .NCH(NCH)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cyc_o(cyc), .ch_o(ch), .phase_o(phase), .last_o(last)
  );

  assign sub = SW'(ch >> MW);

  for (genvar g = 0; g < NSUB; g++) begin : g_sar
    sarseq_sar_core #(
      .RES(RES), .SAMPLE_CYC(SAMPLE_CYC), .CW(CW)
    ) u_sar (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .active_i(sub == SW'(g)), .phase_i(phase), .cyc_i(cyc),
      .cmp_i(cmp_i[g]), .code_o(dac_code_o[g*RES +: RES])
    );
  end

  sarseq_serializer #(
    .RES(RES), .NSUB(NSUB), .CW(CW)
  ) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .last_i(last), .cyc_i(cyc), .sub_i(sub), .word_i(dac_code_o),
    .dout_o(dout_o), .frame_o(frame_o), .dsel_o(dsel_o)
  );

  assign ch_sel_o = ch;
  assign eoc_o    = last;

  AST_EOC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o); // R1
  AST_EOC_TO_FRAME_DSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> (dsel_o != '0)); // R8
endmodule

// File: tb/sim_mc_sar_sequencer.sv
`timescale 1ns/1ps
module sim_mc_sar_sequencer;
  localparam int CLK_PERIOD = 400;
  localparam int RES   = 10;
  localparam int NSUB  = 2;
  localparam int NCH   = 16;
  localparam int SLOT  = 24;
  localparam int ROUNDS = 3;
  // per-channel comparator thresholds (stimulus) = expected converted words
  localparam int TBL [16] = '{0, 1023, 512, 511, 682, 341, 1, 1022,
                              100, 900, 256, 768, 37, 987, 640, 383};

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic [NSUB-1:0]     cmp;
  logic [NSUB*RES-1:0] dac_code;
  logic [3:0]          ch_sel;
  logic                eoc, dout, frame;
  logic [NSUB-1:0]     dsel;

  int errors = 0;
  int checks = 0;
  int bcyc = 0;
  int cur_ch = 0;
  int brnd = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_sar_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmp_i(cmp), .dac_code_o(dac_code),
    .ch_sel_o(ch_sel), .eoc_o(eoc), .dsel_o(dsel), .dout_o(dout), .frame_o(frame)
  );

  function automatic int tgt_f(int ch, int rnd);
    return TBL[(ch + 3*rnd) % 16];
  endfunction

  function automatic int dac_of(int s);
    return int'(dac_code[s*RES +: RES]);
  endfunction

  // ideal comparator during decisions; alternating noise elsewhere (R3, R4)
  always_comb begin
    for (int s = 0; s < NSUB; s++) begin
      if (bcyc >= 13 && bcyc < 23)
        cmp[s] = (dac_of(s) <= tgt_f(cur_ch, brnd));
      else
        cmp[s] = bcyc[0] ^ s[0];
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one slot; slot number counted from the last reset
  task automatic run_slot(int slot);
    int ch, act, ina, pch, pword;
    ch   = slot % NCH;
    act  = ch / 8;
    ina  = 1 - act;
    pch  = (slot + NCH - 1) % NCH;
    pword = (slot > 0) ? tgt_f(pch, (slot - 1) / NCH) : 0;
    cur_ch = ch;
    brnd   = slot / NCH;
    for (int c = 0; c < SLOT; c++) begin
      bcyc = c;
      #1;
      if (c == 0)  chk("R5 channel order", int'(ch_sel), ch);
      if (c == 23) chk("R6 channel stable", int'(ch_sel), ch);
      chk("R1 eoc strobe", int'(eoc), (c == 23) ? 1 : 0);
      if (c == 6)  chk("R3 sample code zero", dac_of(act), 0);
      if (c == 13) chk("R2 trial msb", dac_of(act), 512);
      if (c == 23) chk("R2 final word", dac_of(act), tgt_f(ch, brnd));
      if (c == 13 || c == 23) chk("R4 idle group code", dac_of(ina), 0);
      if (c < 2)   chk("R7 frame", int'(frame), (c == 0 && slot > 0) ? 1 : 0);
      if (slot > 0 && c < RES)
        chk("R7 serial bit", int'(dout), (pword >> (RES-1-c)) & 1);
      else if (c == 12 || c == 23 || slot == 0)
        chk("R7 serial idle", int'(dout), 0);
      if (c == 5)
        chk("R8 digital select", int'(dsel), (slot > 0) ? (1 << (pch / 8)) : 0);
      @(negedge clk);
    end
  endtask

  initial begin
    bcyc = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset channel", int'(ch_sel), 0);
    chk("R9 reset eoc", int'(eoc), 0);
    chk("R9 reset dsel", int'(dsel), 0);
    chk("R9 reset code", int'(dac_code), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    // table walk: three rotations plus one slot to drain the last word
    for (int s = 0; s <= ROUNDS*NCH; s++) run_slot(s);
    // reset during a conversion with a word pending
    for (int c = 1; c < 17; c++) begin bcyc = c; @(negedge clk); end
    rst_ni = 1'b0;
    bcyc = 0;
    #1;
    chk("R9 midconv channel", int'(ch_sel), 0);
    chk("R9 midconv code", int'(dac_code), 0);
    chk("R9 midconv eoc", int'(eoc), 0);
    chk("R9 midconv frame", int'(frame), 0);
    chk("R9 midconv dout", int'(dout), 0);
    chk("R9 midconv dsel", int'(dsel), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    run_slot(0);   // R9: no frame in first slot after reset
    run_slot(1);
    run_slot(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule